// File: doc/BRIEF.md
# Host Port Mailbox and Data Selector

This block sits on the device side of an 8-bit bidirectional parallel bus. Two select lines from the host decide which byte the device places on the data lines: a sample from channel A, a sample from channel B, the content of a one-byte mailbox, or a fixed identification byte. The host flips the bus direction through a separate direction line. The device drives the bus only while the host has turned its own drivers off.

The mailbox is the command path between the host and the internal controller, and it carries bytes both ways. Each side sees the byte that the other side wrote last. After its own write, a side sees zero until the other side answers. Zero therefore means "nothing new", and a zero byte cannot be sent.

A strobe line from the host plays two roles. While a channel is selected in readout mode, each strobe steps the sample readout pointer to the next address of the capture buffer. While the mailbox is selected and the host is driving, the strobe writes the host's byte into the mailbox. In scroll mode the channel selections show the live converter values, and strobes leave the pointer where it is. All host lines are asynchronous and pass through synchronizer stages before use.

Top module: `hpmb_port`

## Requirements
- R1: While reset is held and directly after it, `pd_oe` is 0, `buf_addr` is 0, `ctl_rx_byte` is 0 and `pd_out` is 0. The mailbox starts empty, so with the mailbox selected the host reads 0.
- R2: With `port_sel` = 2'b00 (channel A), `pd_out` shows `buf_data_a` for the current `buf_addr` in readout mode.
- R3: With `port_sel` = 2'b01 (channel B), `pd_out` shows `buf_data_b` for the current `buf_addr` in readout mode.
- R4: With `port_sel` = 2'b11, `pd_out` shows the identification byte 8'h55.
- R5: A rising edge of `strobe_n` while `port_sel` = 2'b10 (mailbox) and `host_rd` = 0 stores `pd_in` in the mailbox. It raises `ctl_rx_valid` for exactly one clock cycle, and `ctl_rx_byte` then shows the stored byte.
- R6: After a host write, `pd_out` reads 0 on the mailbox selection until the controller writes. After a controller write (`ctl_wr_en`), the host reads the controller's byte and `ctl_rx_byte` reads 0. If both sides write in the same cycle, the controller's write wins.
- R7: In readout mode, a rising edge of `strobe_n` while a channel is selected (`port_sel[1]` = 0) adds 1 to `buf_addr`. The address wraps from DEPTH-1 to 0, and `ptr_rewind` sets it to 0.
- R8: With `scroll_mode` = 1, channel A shows `adc_a` and channel B shows `adc_b`, and strobes do not move `buf_addr`.
- R9: `pd_oe` follows `host_rd` through the synchronizer. When `host_rd` = 0, the device never drives the bus.
- R10: A strobe with the mailbox selected leaves `buf_addr` unchanged. A strobe with a channel selected, or with `host_rd` = 1, does not write the mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_in | input | 8 | Data lines as driven by the host |
| pd_out | output | 8 | Byte the device places on the data lines |
| pd_oe | output | 1 | Output enable for the device's data drivers |
| host_rd | input | 1 | Host has set the bus to input (device may drive) |
| port_sel | input | 2 | Source select: 00 channel A, 01 channel B, 10 mailbox, 11 identification |
| strobe_n | input | 1 | Active-low strobe; its rising edge acts |
| scroll_mode | input | 1 | 1: live converter values; 0: buffered readout |
| ptr_rewind | input | 1 | Controller resets the readout pointer to 0 |
| buf_addr | output | AW | Readout address into the capture buffers |
| buf_data_a | input | 8 | Channel A buffer byte at `buf_addr` |
| buf_data_b | input | 8 | Channel B buffer byte at `buf_addr` |
| adc_a | input | 8 | Live channel A converter value |
| adc_b | input | 8 | Live channel B converter value |
| ctl_wr_en | input | 1 | Controller writes `ctl_wr_byte` into the mailbox |
| ctl_wr_byte | input | 8 | Byte written by the controller |
| ctl_rx_byte | output | 8 | Controller's view of the mailbox (0 when empty) |
| ctl_rx_valid | output | 1 | One-cycle pulse when a host byte is stored |

## Verification
The bench builds the block with DEPTH = 8 and two synchronizer stages. The small depth lets a handful of strobes carry the readout pointer through its wrap from 7 back to 0. Two synchronizer stages keep the delay from a pin change to the output short and fixed, so each expected byte can be sampled at a known cycle. The buffer contents are a simple function of the address, so every pointer position has its own value on both channels.

// File: rtl/hpmb_pkg.sv
package hpmb_pkg;

    localparam logic [7:0] ID_BYTE = 8'h55;

    typedef enum logic [1:0] {
        SRC_CHA  = 2'b00,
        SRC_CHB  = 2'b01,
        SRC_MBOX = 2'b10,
        SRC_ID   = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_CTL  = 2'd2
    } owner_e;

    typedef struct packed {
        logic [7:0] data;
        logic [1:0] sel;
        logic       dir_in;
        logic       strobe_n;
    } host_pins_t;

    localparam int PINS_W = $bits(host_pins_t);

    function automatic logic is_channel(input src_e s);
        return (s == SRC_CHA) || (s == SRC_CHB);
    endfunction

    function automatic logic [7:0] view_for(input owner_e own, input owner_e viewer_peer,
                                            input logic [7:0] b);
        return (own == viewer_peer) ? b : 8'h00;
    endfunction

endpackage

// File: rtl/hpmb_sync.sv
module hpmb_sync #(
    parameter int                WIDTH   = 12,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) st[i] <= RST_VAL;
                    else     st[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) st[i] <= RST_VAL;
                    else     st[i] <= st[i-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/hpmb_mailbox.sv
module hpmb_mailbox
    import hpmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [7:0] host_byte,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_byte,
    output logic [7:0] host_view,
    output logic [7:0] ctl_view,
    output logic       rx_valid
);
    owner_e     owner;
    logic [7:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner    <= OWN_NONE;
            slot     <= 8'h00;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (ctl_wr) begin
                owner <= OWN_CTL;
                slot  <= ctl_byte;
            end else if (host_wr) begin
                owner    <= OWN_HOST;
                slot     <= host_byte;
                rx_valid <= 1'b1;
            end
        end
    end

    assign host_view = view_for(owner, OWN_CTL, slot);
    assign ctl_view  = view_for(owner, OWN_HOST, slot);
endmodule

// File: rtl/hpmb_readout.sv
module hpmb_readout
    import hpmb_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_rise,
    input  src_e          sel,
    input  logic          scroll_mode,
    input  logic          rewind,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic step;
    assign step = strobe_rise && is_channel(sel) && !scroll_mode;

    always_ff @(posedge clk) begin
        if (rst || rewind) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/hpmb_port.sv
module hpmb_port
    import hpmb_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    pd_in,
    output logic [7:0]    pd_out,
    output logic          pd_oe,
    input  logic          host_rd,
    input  logic [1:0]    port_sel,
    input  logic          strobe_n,
    input  logic          scroll_mode,
    input  logic          ptr_rewind,
    output logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_data_a,
    input  logic [7:0]    buf_data_b,
    input  logic [7:0]    adc_a,
    input  logic [7:0]    adc_b,
    input  logic          ctl_wr_en,
    input  logic [7:0]    ctl_wr_byte,
    output logic [7:0]    ctl_rx_byte,
    output logic          ctl_rx_valid
);
    localparam host_pins_t PINS_IDLE = '{data: 8'h00, sel: 2'b00, dir_in: 1'b0, strobe_n: 1'b1};

    host_pins_t pins_raw, pins_s;
    src_e       sel_s;
    logic       dir_s;
    logic       strb_prev;
    logic       strobe_rise;
    logic       host_wr;
    logic [7:0] host_view;

    assign pins_raw = '{data: pd_in, sel: port_sel, dir_in: host_rd, strobe_n: strobe_n};

    hpmb_sync #(
        .WIDTH  (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins_raw),
        .q  (pins_s)
    );

    assign sel_s = src_e'(pins_s.sel);
    assign dir_s = pins_s.dir_in;

    always_ff @(posedge clk) begin
        if (rst) strb_prev <= 1'b1;
        else     strb_prev <= pins_s.strobe_n;
    end

    assign strobe_rise = pins_s.strobe_n && !strb_prev;
    assign host_wr     = strobe_rise && (sel_s == SRC_MBOX) && !dir_s;

    hpmb_mailbox u_mbox (
        .clk      (clk),
        .rst      (rst),
        .host_wr  (host_wr),
        .host_byte(pins_s.data),
        .ctl_wr   (ctl_wr_en),
        .ctl_byte (ctl_wr_byte),
        .host_view(host_view),
        .ctl_view (ctl_rx_byte),
        .rx_valid (ctl_rx_valid)
    );

    hpmb_readout #(
        .DEPTH(DEPTH)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .strobe_rise(strobe_rise),
        .sel        (sel_s),
        .scroll_mode(scroll_mode),
        .rewind     (ptr_rewind),
        .ptr        (buf_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_out <= 8'h00;
            pd_oe  <= 1'b0;
        end else begin
            pd_oe <= dir_s;
            unique case (sel_s)
                SRC_CHA:  pd_out <= scroll_mode ? adc_a : buf_data_a;
                SRC_CHB:  pd_out <= scroll_mode ? adc_b : buf_data_b;
                SRC_MBOX: pd_out <= host_view;
                SRC_ID:   pd_out <= ID_BYTE;
                default:  pd_out <= 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/hpmb_port_chk.sv
module hpmb_port_chk
    import hpmb_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    sel_s,
    input logic          dir_s,
    input logic          scroll_mode,
    input logic          ptr_rewind,
    input logic [AW-1:0] buf_addr,
    input logic [7:0]    pd_out,
    input logic          pd_oe,
    input logic          ctl_wr_en,
    input logic [7:0]    ctl_rx_byte,
    input logic          ctl_rx_valid
);
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ctl_rx_valid |=> !ctl_rx_valid); // R5

    AST_CTL_SEES_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_en |=> (ctl_rx_byte == 8'h00)); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !ptr_rewind |=> (buf_addr == $past(buf_addr) ||
                         buf_addr == $past(buf_addr) + 1'b1 ||
                         buf_addr == '0)); // R7

    AST_SCROLL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (scroll_mode && !ptr_rewind) |=> $stable(buf_addr)); // R8

    AST_ID_BYTE: assert property (@(posedge clk) disable iff (rst)
        (sel_s == SRC_ID) |=> (pd_out == ID_BYTE)); // R4

    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !dir_s |=> !pd_oe); // R9
endmodule

bind hpmb_port hpmb_port_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_s       (pins_s.sel),
    .dir_s       (dir_s),
    .scroll_mode (scroll_mode),
    .ptr_rewind  (ptr_rewind),
    .buf_addr    (buf_addr),
    .pd_out      (pd_out),
    .pd_oe       (pd_oe),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_rx_byte (ctl_rx_byte),
    .ctl_rx_valid(ctl_rx_valid)
);

// File: tb/hpmb_port_bench.sv
`timescale 1ns/1ps
module hpmb_port_bench;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    localparam int K_OUT = 0, K_OE = 1, K_ADDR = 2, K_CTL = 3, K_PULSES = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    pd_in = 8'h00;
    logic [7:0]    pd_out;
    logic          pd_oe;
    logic          host_rd = 1'b0;
    logic [1:0]    port_sel = 2'b00;
    logic          strobe_n = 1'b1;
    logic          scroll_mode = 1'b0;
    logic          ptr_rewind = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_data_a, buf_data_b;
    logic [7:0]    adc_a = 8'h6E;
    logic [7:0]    adc_b = 8'h91;
    logic          ctl_wr_en = 1'b0;
    logic [7:0]    ctl_wr_byte = 8'h00;
    logic [7:0]    ctl_rx_byte;
    logic          ctl_rx_valid;

    int checks = 0;
    int errors = 0;
    int rx_pulses = 0;
    bit done = 0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_a(input int a);
        return 8'((a * 3) + 1);
    endfunction
    function automatic logic [7:0] mem_b(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    assign buf_data_a = mem_a(int'(buf_addr));
    assign buf_data_b = mem_b(int'(buf_addr));

    hpmb_port #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_hpmb_port (
        .clk(clk), .rst(rst), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .host_rd(host_rd), .port_sel(port_sel), .strobe_n(strobe_n),
        .scroll_mode(scroll_mode), .ptr_rewind(ptr_rewind), .buf_addr(buf_addr),
        .buf_data_a(buf_data_a), .buf_data_b(buf_data_b), .adc_a(adc_a), .adc_b(adc_b),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_byte(ctl_wr_byte),
        .ctl_rx_byte(ctl_rx_byte), .ctl_rx_valid(ctl_rx_valid)
    );

    // monitor: count valid pulses and score queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (ctl_rx_valid) rx_pulses++;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sb.pop_front();
                case (it.kind)
                    K_OUT:   got = pd_out;
                    K_OE:    got = {7'd0, pd_oe};
                    K_ADDR:  got = 8'(buf_addr);
                    K_CTL:   got = ctl_rx_byte;
                    default: got = 8'(rx_pulses);
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic settle_expect(input int kind, input logic [7:0] exp, input string req);
        cyc(6);
        expect_item(kind, exp, req);
        cyc(1);
    endtask

    task automatic strobe_pulse();
        strobe_n = 1'b0;
        cyc(4);
        strobe_n = 1'b1;
        cyc(4);
    endtask

    task automatic ctl_write(input logic [7:0] b);
        ctl_wr_byte = b;
        ctl_wr_en   = 1'b1;
        cyc(1);
        ctl_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: state under reset
        expect_item(K_OUT, 8'h00, "R1 pd_out in reset");
        expect_item(K_OE, 8'h00, "R1 pd_oe in reset");
        expect_item(K_ADDR, 8'h00, "R1 addr in reset");
        expect_item(K_CTL, 8'h00, "R1 ctl view in reset");
        cyc(1);
        rst = 1'b0;

        // R1/R9: empty mailbox read by host, device drives
        host_rd = 1'b1; port_sel = 2'b10;
        settle_expect(K_OUT, 8'h00, "R1 empty mailbox");
        expect_item(K_OE, 8'h01, "R9 oe follows host_rd");
        cyc(1);

        port_sel = 2'b00; settle_expect(K_OUT, mem_a(0), "R2 channel A at 0");
        port_sel = 2'b01; settle_expect(K_OUT, mem_b(0), "R3 channel B at 0");
        port_sel = 2'b11; settle_expect(K_OUT, 8'h55, "R4 id byte");
        host_rd = 1'b0;   settle_expect(K_OE, 8'h00, "R9 no drive when host drives");

        // R7: pointer steps
        host_rd = 1'b1; port_sel = 2'b00;
        for (int i = 0; i < 3; i++) strobe_pulse();
        settle_expect(K_ADDR, 8'd3, "R7 three steps");
        expect_item(K_OUT, mem_a(3), "R2 channel A at 3");
        cyc(1);
        port_sel = 2'b01; settle_expect(K_OUT, mem_b(3), "R3 channel B at 3");
        for (int i = 0; i < 5; i++) strobe_pulse();
        settle_expect(K_ADDR, 8'd0, "R7 wrap to 0");
        strobe_pulse(); strobe_pulse();
        settle_expect(K_ADDR, 8'd2, "R7 step after wrap");
        ptr_rewind = 1'b1; cyc(1); ptr_rewind = 1'b0;
        settle_expect(K_ADDR, 8'd0, "R7 rewind");

        // R8: scroll mode
        scroll_mode = 1'b1; port_sel = 2'b00;
        settle_expect(K_OUT, 8'h6E, "R8 live A");
        port_sel = 2'b01;
        settle_expect(K_OUT, 8'h91, "R8 live B");
        strobe_pulse();
        settle_expect(K_ADDR, 8'd0, "R8 strobe ignored");
        scroll_mode = 1'b0;

        // R5: host write
        port_sel = 2'b10; host_rd = 1'b0; pd_in = 8'h5A;
        cyc(4);
        strobe_pulse();
        settle_expect(K_PULSES, 8'd1, "R5 one pulse");
        expect_item(K_CTL, 8'h5A, "R5 ctl sees host byte");
        cyc(1);
        // R6: host sees zero after own write
        host_rd = 1'b1;
        settle_expect(K_OUT, 8'h00, "R6 host reads 0 after own write");
        ctl_write(8'hC3);
        settle_expect(K_OUT, 8'hC3, "R6 host sees controller byte");
        expect_item(K_CTL, 8'h00, "R6 ctl reads 0 after own write");
        cyc(1);

        // R10: mailbox strobe with host reading: no pointer step, no write
        pd_in = 8'h11;
        strobe_pulse();
        settle_expect(K_ADDR, 8'd0, "R10 mailbox strobe no step");
        expect_item(K_OUT, 8'hC3, "R10 host_rd strobe no write");
        expect_item(K_PULSES, 8'd1, "R10 no pulse");
        cyc(1);
        // R10: channel strobe with host driving: steps pointer, no write
        port_sel = 2'b00; host_rd = 1'b0; pd_in = 8'h77;
        cyc(4);
        strobe_pulse();
        settle_expect(K_CTL, 8'h00, "R10 channel strobe no write");
        expect_item(K_ADDR, 8'd1, "R7 channel strobe steps");
        expect_item(K_PULSES, 8'd1, "R10 pulse count unchanged");
        cyc(1);

        // R5/R6: second host write after controller answer
        port_sel = 2'b10; pd_in = 8'h81;
        cyc(4);
        strobe_pulse();
        settle_expect(K_CTL, 8'h81, "R5 second host byte");
        expect_item(K_PULSES, 8'd2, "R5 second pulse");
        cyc(1);
        host_rd = 1'b1;
        settle_expect(K_OUT, 8'h00, "R6 host reads 0 again");

        cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule